// File: doc/BRIEF.md
# Dual-Channel Bitstream FIR Decimator

This block turns two one-bit sigma-delta modulator streams, I and Q, into 12-bit signed samples. Every input bit stands for +1 (bit 1) or −1 (bit 0). Each channel keeps a 288-stage delay line of recent bits and filters it with a symmetric, linear-phase low-pass coefficient set. Because every input is ±1, each tap adds or subtracts its coefficient, so the filter needs no multipliers. A result is computed once every 24 accepted samples. A time-multiplexed accumulator works through a snapshot of the delay line, several taps per fast-clock cycle. The sum is rounded, saturated to 12 bits and presented with a one-cycle strobe.

Input samples arrive on a clock-enable pulse at half the master clock rate. A sleep control parks the block. While asleep, it ignores its inputs and drops any sum in progress. The first accepted sample after sleep clears both delay lines. The strobe then stays low until the lines have been refilled with 288 fresh samples, and the same holds after reset.

Top module: `bsd_decim_top`

## Requirements
- R1: After reset `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: Tap k (k = 0 is the newest sample) carries coefficient c_k = min(k, 287−k) + 1. A bit of 1 counts as +1 and a bit of 0 as −1. Each result is floor((Σ c_k·s_k + 4) / 8), saturated to 12 bits.
- R3: One result is taken every 24 accepted samples. The capture happens on the sample that completes a group of 24, counted from reset or wake. `out_valid` rises exactly 36 clock edges after that sample's enable edge and lasts one cycle.
- R4: Out-of-range results saturate: an all-ones history gives +2047 and an all-zeros history gives −2048.
- R5: Because the coefficients are symmetric, a strictly alternating history (1,0,1,0,…) over all 288 taps gives exactly 0.
- R6: After reset or wake, no strobe is produced until 288 samples have been accepted. The first strobe belongs to the capture made on the 288th sample.
- R7: While `sleep` is 1, `sample_en` and the modulator bits are ignored and `out_valid` stays 0. A sum in progress is dropped.
- R8: `out_i` and `out_q` change only in a cycle where `out_valid` is 1, and hold their value otherwise.
- R9: The I and Q channels are filtered identically and independently, each from its own input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One pulse per modulator sample (half master rate) |
| sleep | input | 1 | Standby request; 1 parks the block |
| mod_i | input | 1 | I-channel modulator bit |
| mod_q | input | 1 | Q-channel modulator bit |
| out_valid | output | 1 | One-cycle strobe marking a new result pair |
| out_i | output | 12 | I-channel filtered sample, two's complement |
| out_q | output | 12 | Q-channel filtered sample, two's complement |

## Verification
The hardest condition to reach is the refill after a wake. Only the moment of the first strobe shows that the fill count restarted, because the cleared taps themselves never reach an output. The stimulus sleeps between segments and feeds junk enables while asleep. After waking, it splits the 288 fresh samples across two segments with different patterns. The bench records the clock edge of the 288th post-wake sample and requires the first strobe exactly 36 edges later.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    // Symmetric triangular low-pass coefficient for tap k of a taps-long line.
    function automatic int coef_of(int k, int taps);
        int m;
        m = (k < taps - 1 - k) ? k : taps - 1 - k;
        return m + 1;
    endfunction

    // Round-half-up by 2**shift, then clamp to a signed out_w-bit range.
    function automatic int round_sat(int acc, int shift, int out_w);
        int r;
        int hi;
        int lo;
        r  = (acc + (1 <<< (shift - 1))) >>> shift;
        hi = (1 <<< (out_w - 1)) - 1;
        lo = -(1 <<< (out_w - 1));
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/bsd_coef_rom.sv
module bsd_coef_rom #(
    parameter int TAPS   = 288,
    parameter int COEF_W = 16
) (
    output logic signed [COEF_W-1:0] coef [TAPS]
);
    for (genvar k = 0; k < TAPS; k++) begin : g_coef
        assign coef[k] = COEF_W'(bsd_pkg::coef_of(k, TAPS));
    end
endmodule

// File: rtl/bsd_tap_line.sv
module bsd_tap_line #(
    parameter int TAPS = 288
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic            clear,
    input  logic            bit_in,
    output logic [TAPS-1:0] taps_next
);
    logic [TAPS-1:0] taps_q;

    always_comb begin
        taps_next = taps_q;
        if (shift) begin
            if (clear) taps_next = {{(TAPS-1){1'b0}}, bit_in};
            else       taps_next = {taps_q[TAPS-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= taps_next;
    end
endmodule

// File: rtl/bsd_lane_mac.sv
module bsd_lane_mac #(
    parameter int TAPS   = 288,
    parameter int LANES  = 8,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 26,
    parameter int STEP_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [TAPS-1:0]          taps_in,
    input  logic signed [COEF_W-1:0] coef [TAPS],
    input  logic [STEP_W-1:0]        step,
    output logic signed [ACC_W-1:0]  partial
);
    logic [TAPS-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap_q <= '0;
        else if (load) snap_q <= taps_in;
    end

    always_comb begin
        partial = '0;
        for (int l = 0; l < LANES; l++) begin
            int idx;
            idx = int'(step) * LANES + l;
            if (idx < TAPS) begin
                if (snap_q[idx]) partial = partial + ACC_W'(coef[idx]);
                else             partial = partial - ACC_W'(coef[idx]);
            end
        end
    end
endmodule

// File: rtl/bsd_decim_top.sv
module bsd_decim_top #(
    parameter int TAPS        = 288,
    parameter int DECIM       = 24,
    parameter int LANES       = 8,
    parameter int COEF_W      = 16,
    parameter int OUT_W       = 12,
    parameter int ROUND_SHIFT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic                    sleep,
    input  logic                    mod_i,
    input  logic                    mod_q,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int STEPS  = (TAPS + LANES - 1) / LANES;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int FILL_W = $clog2(TAPS + 1);
    localparam int ACC_W  = COEF_W + $clog2(TAPS) + 1;

    typedef struct packed {
        logic [PH_W-1:0]          phase;
        logic [FILL_W-1:0]        fill;
        logic                     wake_pend;
        logic                     busy;
        logic                     good;
        logic [STEP_W-1:0]        step;
        logic signed [ACC_W-1:0]  acc_i;
        logic signed [ACC_W-1:0]  acc_q;
        logic signed [OUT_W-1:0]  out_i;
        logic signed [OUT_W-1:0]  out_q;
        logic                     valid;
    } state_t;

    state_t st_d, st_q;

    logic                     accept, clear_line, capture;
    logic [PH_W-1:0]          base_ph;
    logic [FILL_W-1:0]        base_fill, fill_nx;
    logic signed [ACC_W-1:0]  sum_i, sum_q;

    logic signed [COEF_W-1:0] coef [TAPS];
    logic                     ch_bit  [2];
    logic [TAPS-1:0]          ch_taps [2];
    logic signed [ACC_W-1:0]  ch_part [2];

    assign ch_bit[0] = mod_i;
    assign ch_bit[1] = mod_q;

    bsd_coef_rom #(.TAPS(TAPS), .COEF_W(COEF_W)) u_rom (.coef(coef));

    for (genvar c = 0; c < 2; c++) begin : g_chan
        bsd_tap_line #(.TAPS(TAPS)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift     (accept),
            .clear     (clear_line),
            .bit_in    (ch_bit[c]),
            .taps_next (ch_taps[c])
        );
        bsd_lane_mac #(
            .TAPS(TAPS), .LANES(LANES), .COEF_W(COEF_W),
            .ACC_W(ACC_W), .STEP_W(STEP_W)
        ) u_mac (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (capture),
            .taps_in (ch_taps[c]),
            .coef    (coef),
            .step    (st_q.step),
            .partial (ch_part[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        accept     = sample_en && !sleep;
        clear_line = accept && st_q.wake_pend;
        capture    = 1'b0;
        base_ph    = clear_line ? '0 : st_q.phase;
        base_fill  = clear_line ? '0 : st_q.fill;
        fill_nx    = (base_fill == FILL_W'(TAPS)) ? base_fill : base_fill + 1'b1;
        sum_i      = st_q.acc_i + ch_part[0];
        sum_q      = st_q.acc_q + ch_part[1];

        if (sleep) begin
            st_d.wake_pend = 1'b1;
            st_d.busy      = 1'b0;
        end

        // Time-multiplexed accumulation over the captured snapshot.
        if (st_q.busy && !sleep) begin
            if (st_q.step == STEP_W'(STEPS - 1)) begin
                st_d.busy = 1'b0;
                if (st_q.good) begin
                    st_d.out_i = OUT_W'(bsd_pkg::round_sat(int'(sum_i), ROUND_SHIFT, OUT_W));
                    st_d.out_q = OUT_W'(bsd_pkg::round_sat(int'(sum_q), ROUND_SHIFT, OUT_W));
                    st_d.valid = 1'b1;
                end
            end else begin
                st_d.acc_i = sum_i;
                st_d.acc_q = sum_q;
                st_d.step  = st_q.step + 1'b1;
            end
        end

        // Sample intake, decimation phase and settling count.
        if (accept) begin
            st_d.wake_pend = 1'b0;
            st_d.fill      = fill_nx;
            if (base_ph == PH_W'(DECIM - 1)) begin
                st_d.phase = '0;
                capture    = 1'b1;
                st_d.busy  = 1'b1;
                st_d.step  = '0;
                st_d.acc_i = '0;
                st_d.acc_q = '0;
                st_d.good  = (fill_nx == FILL_W'(TAPS));
            end else begin
                st_d.phase = base_ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_i     = st_q.out_i;
    assign out_q     = st_q.out_q;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
    parameter int TAPS  = 288,
    parameter int OUT_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_en,
    input logic                    sleep,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q
);
    // Independent count of samples accepted since reset or wake.
    int   seen_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 0;
            pend_q <= 1'b0;
        end else if (sleep) begin
            pend_q <= 1'b1;
        end else if (sample_en) begin
            pend_q <= 1'b0;
            if (pend_q)            seen_q <= 1;
            else if (seen_q < TAPS) seen_q <= seen_q + 1;
        end
    end

    a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !out_valid);

    a_r6_settled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q >= TAPS));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_hold_i: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_i));

    a_r8_hold_q: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_q));
endmodule

bind bsd_decim_top bsd_checker #(.TAPS(TAPS), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .sleep     (sleep),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_bsd_decim_top.sv
module sim_bsd_decim_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 288;
    localparam int DECIM = 24;
    localparam int LANES = 8;
    localparam int STEPS = TAPS / LANES;

    typedef struct packed {
        int pi;
        int pq;
        int n;
        bit slp;
    } vec_t;

    // pattern codes: 0 zeros, 1 ones, 2 alternating, 3 three-of-four, 4 hash, 5 one-of-four
    localparam vec_t VECS [6] = '{
        '{1, 0, 336, 1'b0},
        '{2, 3, 336, 1'b0},
        '{4, 5, 240, 1'b0},
        '{0, 2, 120, 1'b1},
        '{3, 4, 300, 1'b0},
        '{5, 1, 240, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic sleep = 1'b0;
    logic mod_i = 1'b0;
    logic mod_q = 1'b0;
    logic out_valid;
    logic signed [11:0] out_i, out_q;

    bsd_decim_top u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sleep(sleep),
        .mod_i(mod_i), .mod_q(mod_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;
    bit running  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural model state
    bit mi [TAPS];
    bit mq [TAPS];
    int m_fill = 0;
    int m_phase = 0;
    bit m_pend = 1'b0;
    int wake_cnt = 0;
    int t288 = -1;
    int first_cyc = -1;
    bit watch_first = 1'b0;
    int sleep_strobes = 0;
    int last_i = 0;
    int last_q = 0;

    typedef struct {
        int ei;
        int eq;
        int cap;
    } exp_t;
    exp_t expq [$];

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int coef(int k);
        int m;
        m = (k < TAPS - 1 - k) ? k : TAPS - 1 - k;
        return m + 1;
    endfunction

    function automatic int model_out(bit line [TAPS]);
        int acc;
        int r;
        acc = 0;
        for (int k = 0; k < TAPS; k++) acc += line[k] ? coef(k) : -coef(k);
        r = (acc + 4) >>> 3;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    function automatic bit pat_bit(int p, int idx);
        int h;
        case (p)
            0: return 1'b0;
            1: return 1'b1;
            2: return bit'(idx & 1);
            3: return (idx % 4) != 0;
            4: begin
                h = idx * 1103515245 + 12345;
                return bit'((h >>> 16) & 1);
            end
            default: return (idx % 4) == 0;
        endcase
    endfunction

    task automatic push_sample(bit bi, bit bq);
        @(negedge clk);
        sample_en = 1'b1;
        mod_i = bi;
        mod_q = bq;
        @(negedge clk);
        sample_en = 1'b0;
        if (!sleep) begin
            if (m_pend) begin
                for (int k = 0; k < TAPS; k++) begin
                    mi[k] = 1'b0;
                    mq[k] = 1'b0;
                end
                m_fill = 0;
                m_phase = 0;
                m_pend = 1'b0;
            end
            for (int k = TAPS - 1; k > 0; k--) begin
                mi[k] = mi[k-1];
                mq[k] = mq[k-1];
            end
            mi[0] = bi;
            mq[0] = bq;
            if (m_fill < TAPS) m_fill++;
            wake_cnt++;
            if (wake_cnt == TAPS) t288 = cyc;
            if (m_phase == DECIM - 1) begin
                m_phase = 0;
                if (m_fill == TAPS) expq.push_back('{model_out(mi), model_out(mq), cyc});
            end else begin
                m_phase++;
            end
        end
    endtask

    // Strobe monitor: compares each result with the model (R2, R3, R9, R7, R8)
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (out_valid) begin
                if (sleep) begin
                    sleep_strobes++;
                    check(1'b0, "R7 strobe during sleep", 1, 0);
                end
                if (watch_first && first_cyc < 0) first_cyc = cyc;
                if (expq.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(int'(out_i) == e.ei, "R2 I result", int'(out_i), e.ei);
                    check(int'(out_q) == e.eq, "R9 Q result", int'(out_q), e.eq);
                    check(cyc - e.cap == STEPS, "R3 latency", cyc - e.cap, STEPS);
                end
                last_i = int'(out_i);
                last_q = int'(out_q);
            end else if (int'(out_i) != last_i || int'(out_q) != last_q) begin
                check(1'b0, "R8 output moved without strobe", int'(out_i), last_i);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sleep_episode();
        idle(40);
        sleep = 1'b1;
        m_pend = 1'b1;
        wake_cnt = 0;
        t288 = -1;
        first_cyc = -1;
        watch_first = 1'b1;
        sleep_strobes = 0;
        for (int s = 0; s < 30; s++) push_sample(pat_bit(4, s + 7), pat_bit(2, s));
        idle(5);
        check(sleep_strobes == 0, "R7 quiet while asleep", sleep_strobes, 0);
        @(negedge clk);
        sleep = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < TAPS; k++) begin
            mi[k] = 1'b0;
            mq[k] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(int'(out_i) == 0, "R1 I after reset", int'(out_i), 0);
        check(int'(out_q) == 0, "R1 Q after reset", int'(out_q), 0);
        running = 1'b1;

        for (int v = 0; v < 6; v++) begin
            if (VECS[v].slp) sleep_episode();
            for (int s = 0; s < VECS[v].n; s++)
                push_sample(pat_bit(VECS[v].pi, s), pat_bit(VECS[v].pq, s));
            idle(40);
            check(expq.size() == 0, "R3 all captures produced", expq.size(), 0);
            if (v == 0) begin
                check(int'(out_i) == 2047, "R4 positive saturation", int'(out_i), 2047);
                check(int'(out_q) == -2048, "R4 negative saturation", int'(out_q), -2048);
            end
            if (v == 1) begin
                check(int'(out_i) == 0, "R5 alternating gives zero", int'(out_i), 0);
            end
            if (v == 4) begin
                check(first_cyc - t288 == STEPS, "R6 first strobe after wake",
                      first_cyc - t288, STEPS);
                watch_first = 1'b0;
            end
            if (v == 5) begin
                check(first_cyc < 0, "R6 no strobe before refill", first_cyc, -1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule